// File: doc/BRIEF.md
# Bus-Attached Word Memory with Staged Address

This block is a word-addressed storage port hung on a shared 32-bit data bus. It never takes its access address from the bus in the same cycle as the access. Instead, a separate address register is first loaded from the low bits of the bus, and a later cycle performs the read or the write at whatever address that register holds. A read is combinational from the address register to the read data. A write is stored at a clock edge.

The port models a slow memory. After reset every word is "cold", and the first access to a word is stretched over `LAT` cycles with `busy` high. Once a word has been accessed it is "warm", and later accesses to it complete in the cycle they are issued. During a stretched write, the address and data seen on the first enabled cycle are captured and used for the commit, so the bus is free for other traffic. A stretched access always runs to completion, even if the enable is withdrawn. Read data is presented, with a drive-enable flag for the bus buffer, only when a read can complete in the current cycle.

Top module: `busmem_port`

## Requirements
- R1: When `addr_load` is 1 at a clock edge, the address register takes `bus_in[AW-1:0]`. When `addr_load` is 0, it keeps its value. An access in a cycle uses the value the register held before that edge.
- R2: When `mem_en` is 0 and no stretched access is in progress, nothing is written, `busy` is 0 and `rd_drive` is 0, whatever `mem_wr` and `bus_in` are.
- R3: A read of a warm word (`mem_en`=1, `mem_wr`=0) sets `rd_drive` in the same cycle, and `rd_data` shows the word at the current address.
- R4: A write of a warm word (`mem_en`=1, `mem_wr`=1) stores `bus_in` at the clock edge. A read in the next cycle returns the new value.
- R5: The first access to a word after reset raises `busy` combinationally in its first enabled cycle. `busy` stays high for exactly `LAT` consecutive cycles, and the word then becomes warm.
- R6: Every access to a warm word finishes with `busy` 0 in the cycle it is issued.
- R7: A stretched write stores the address and data seen on its first enabled cycle. Changes to `bus_in` or to the address register during `busy` do not affect what is stored.
- R8: `rd_drive` is 1 only when `mem_en`=1, `mem_wr`=0 and `busy`=0. Whenever `rd_drive` is 0, `rd_data` is all zeros.
- R9: After reset, `busy` and `rd_drive` are 0, the address register is 0, every word holds 0 and every word is cold.
- R10: Once a stretched access has started, it continues for its full `LAT` cycles whether or not `mem_en` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | DW | Current value of the shared bus |
| addr_load | input | 1 | Load the address register from the bus at this edge |
| mem_en | input | 1 | Access enable |
| mem_wr | input | 1 | 1 selects write, 0 selects read (valid when `mem_en` is 1) |
| rd_data | output | DW | Read word, zero when not driving |
| rd_drive | output | 1 | Enable for the bus driver of `rd_data` |
| busy | output | 1 | Access not yet finished |

## Verification
Several properties are checked on every cycle by the assertions. These are: the address-register load and hold behaviour; that the port never drives while busy or on a write; that it is silent when idle with enable low; that the output is zeroed when not driving; and that a busy run lasts exactly `LAT` cycles once begun. Other behaviours can only be shown by the bench's scenarios, because each one links a value stored in one cycle to a read many cycles later. These are: the cold/warm distinction per word; the capture of first-cycle data during a stretched write while the bus changes; reset contents of zero; and a withdrawn enable still completing the access.

// File: rtl/busmem_pkg.sv
// Shared types for the bus-attached word memory.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package busmem_pkg;
    // Controller phase: idle, or waiting out a stretched (cold) access
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } busmem_phase_t;
endpackage

// File: rtl/busmem_addr_reg.sv
// Address register: captures the low bus bits on a load strobe.
// Assumes: the caller passes only the AW address bits of the bus.
module busmem_addr_reg #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    // Edge-load the address, clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/busmem_array.sv
// Word storage: one synchronous write port, one combinational read port.
// Assumes: the depth is 2**AW and small enough to hold in flops that reset to zero.
module busmem_array #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // Clear all words on reset, commit one word per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Combinational read from the addressed word
    always_comb rdata = words[raddr];
endmodule

// File: rtl/busmem_miss_ctrl.sv
// Latency controller: tracks which words are warm, stretches first accesses
// to LAT cycles and produces the single write strobe for the array.
// Assumes: LAT >= 1; the address register feeds cur_addr.
module busmem_miss_ctrl
    import busmem_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 6,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_en,
    input  logic          mem_wr,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] cur_data,
    output logic          busy,
    output logic          we,
    output logic [AW-1:0] we_addr,
    output logic [DW-1:0] we_data
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] warm;
    logic             idle;
    logic             cold_start;
    logic             hot_write;
    logic             fin;
    logic             fin_wr;
    logic [AW-1:0]    fin_addr;
    logic [DW-1:0]    fin_data;

    // Decode the kind of access in this cycle
    always_comb begin
        cold_start = idle && mem_en && !warm[cur_addr];
        hot_write  = idle && mem_en && mem_wr && warm[cur_addr];
        busy       = !idle || cold_start;
    end

    generate
        if (LAT == 1) begin : g_single
            // One-cycle stretch: the cold access finishes at its first edge
            always_comb begin
                idle     = 1'b1;
                fin      = cold_start;
                fin_wr   = mem_wr;
                fin_addr = cur_addr;
                fin_data = cur_data;
            end
        end else begin : g_multi
            localparam int CW = $clog2(LAT);

            busmem_phase_t phase;
            logic [CW-1:0] left;
            logic          h_wr;
            logic [AW-1:0] h_addr;
            logic [DW-1:0] h_data;

            // Enter the wait phase on a cold start, count down to the finishing edge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase  <= PH_IDLE;
                    left   <= '0;
                    h_wr   <= 1'b0;
                    h_addr <= '0;
                    h_data <= '0;
                end else if (phase == PH_IDLE) begin
                    if (cold_start) begin
                        phase  <= PH_WAIT;
                        left   <= CW'(LAT - 1);
                        h_wr   <= mem_wr;
                        h_addr <= cur_addr;
                        h_data <= cur_data;
                    end
                end else begin
                    left <= left - 1'b1;
                    if (left == CW'(1)) phase <= PH_IDLE;
                end
            end

            // The held request finishes on the edge that ends the last busy cycle
            always_comb begin
                idle     = (phase == PH_IDLE);
                fin      = (phase == PH_WAIT) && (left == CW'(1));
                fin_wr   = h_wr;
                fin_addr = h_addr;
                fin_data = h_data;
            end
        end
    endgenerate

    // Mark a word warm when its stretched access finishes
    always_ff @(posedge clk) begin
        if (!rst_n)   warm <= '0;
        else if (fin) warm[fin_addr] <= 1'b1;
    end

    // Select the array write: the finishing stretched write or a warm write
    always_comb begin
        we      = (fin && fin_wr) || hot_write;
        we_addr = (fin && fin_wr) ? fin_addr : cur_addr;
        we_data = (fin && fin_wr) ? fin_data : cur_data;
    end
endmodule

// File: rtl/busmem_port.sv
// Top: bus-attached word memory with a staged address register and
// first-touch latency. Read data is presented only when a read completes.
// Assumes: bus arbitration and the reaction to busy live outside this block.
module busmem_port #(
    parameter int DW  = 32,
    parameter int AW  = 6,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_in,
    input  logic          addr_load,
    input  logic          mem_en,
    input  logic          mem_wr,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive,
    output logic          busy
);
    logic [AW-1:0] addr_q;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;
    logic [DW-1:0] arr_rdata;

    busmem_addr_reg #(.AW(AW)) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (addr_load),
        .d    (bus_in[AW-1:0]),
        .q    (addr_q)
    );

    busmem_miss_ctrl #(.DW(DW), .AW(AW), .LAT(LAT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_en  (mem_en),
        .mem_wr  (mem_wr),
        .cur_addr(addr_q),
        .cur_data(bus_in),
        .busy    (busy),
        .we      (arr_we),
        .we_addr (arr_waddr),
        .we_data (arr_wdata)
    );

    busmem_array #(.DW(DW), .AW(AW)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (arr_we),
        .waddr(arr_waddr),
        .wdata(arr_wdata),
        .raddr(addr_q),
        .rdata(arr_rdata)
    );

    // Present read data only for a read that completes this cycle
    always_comb begin
        rd_drive = mem_en && !mem_wr && !busy;
        rd_data  = rd_drive ? arr_rdata : '0;
    end
endmodule

// File: rtl/busmem_port_chk.sv
// Checker for busmem_port, attached by bind. Watches the ports, the address
// register and the array write strobe.
// Assumes: the same parameter values as the bound instance.
module busmem_port_chk #(
    parameter int DW  = 32,
    parameter int AW  = 6,
    parameter int LAT = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] bus_in,
    input logic          addr_load,
    input logic          mem_en,
    input logic          mem_wr,
    input logic [DW-1:0] rd_data,
    input logic          rd_drive,
    input logic          busy,
    input logic [AW-1:0] addr_q,
    input logic          arr_we
);
    int run;

    // Count the busy cycles that came before the current one in this run
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    assert_addr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> addr_q == $past(bus_in[AW-1:0]));

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_load |=> $stable(addr_q));

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en && !busy) |-> (!arr_we && !rd_drive));

    assert_drive_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> (mem_en && !mem_wr && !busy));

    assert_zero_when_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> rd_data == '0);

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run < LAT);

    assert_busy_continues_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run + 1 < LAT) |=> busy);
endmodule

bind busmem_port busmem_port_chk #(.DW(DW), .AW(AW), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (bus_in),
    .addr_load(addr_load),
    .mem_en   (mem_en),
    .mem_wr   (mem_wr),
    .rd_data  (rd_data),
    .rd_drive (rd_drive),
    .busy     (busy),
    .addr_q   (addr_q),
    .arr_we   (arr_we)
);

// File: tb/sim_busmem_port.sv
// Bench for busmem_port: a behavioural reference model compared every cycle.
module sim_busmem_port;
    localparam int DW  = 32;
    localparam int AW  = 6;
    localparam int LAT = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] bus_in = '0;
    logic          addr_load = 1'b0;
    logic          mem_en = 1'b0;
    logic          mem_wr = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;
    logic          busy;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int          m_addr;
    int unsigned m_mem [DEPTH];
    bit          m_warm [DEPTH];
    int          m_left;
    int          m_haddr;
    int unsigned m_hdata;
    bit          m_hwr;

    busmem_port #(.DW(DW), .AW(AW), .LAT(LAT)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus_in),
        .addr_load(addr_load),
        .mem_en   (mem_en),
        .mem_wr   (mem_wr),
        .rd_data  (rd_data),
        .rd_drive (rd_drive),
        .busy     (busy)
    );

    always #5 clk = ~clk;

    task automatic model_reset();
        m_addr = 0;
        m_left = 0;
        m_haddr = 0;
        m_hdata = 0;
        m_hwr = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            m_mem[i] = 0;
            m_warm[i] = 1'b0;
        end
    endtask

    task automatic model_finish();
        if (m_hwr) m_mem[m_haddr] = m_hdata;
        m_warm[m_haddr] = 1'b1;
    endtask

    // One clock: apply inputs, compare outputs with the model, advance the model
    task automatic step(input bit ld, input bit en, input bit wr,
                        input int unsigned data, input string tag);
        bit          e_busy;
        bit          e_drive;
        int unsigned e_data;
        @(negedge clk);
        addr_load = ld;
        mem_en = en;
        mem_wr = wr;
        bus_in = data;
        #1;
        e_busy  = (m_left > 0) || (en && !m_warm[m_addr]);
        e_drive = en && !wr && !e_busy;
        e_data  = e_drive ? m_mem[m_addr] : 0;
        checks++;
        if (busy !== e_busy || rd_drive !== e_drive || rd_data !== e_data) begin
            errors++;
            $display("FAIL %s: actual busy=%0b drive=%0b data=%h expected busy=%0b drive=%0b data=%h",
                     tag, busy, rd_drive, rd_data, e_busy, e_drive, e_data);
        end
        if (m_left > 0) begin
            m_left--;
            if (m_left == 0) model_finish();
        end else if (en) begin
            if (m_warm[m_addr]) begin
                if (wr) m_mem[m_addr] = data;
            end else begin
                m_haddr = m_addr;
                m_hdata = data;
                m_hwr = wr;
                if (LAT == 1) model_finish();
                else m_left = LAT - 1;
            end
        end
        if (ld) m_addr = int'(data % DEPTH);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog: actual running expected finished");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: idle after reset, nothing driven
        step(0, 0, 0, 32'h0, "R9 reset idle");
        step(0, 0, 1, 32'hFFFF_FFFF, "R2 enable low write ignored");
        // R1 / R5: load address 5, cold read stretches, reset content is zero (R9)
        step(1, 0, 0, 32'd5, "R1 load address");
        for (int i = 0; i < LAT + 1; i++) step(0, 1, 0, 32'h0, "R5 cold read / R9 zero content");
        // R6 / R3: warm read completes at once
        step(0, 1, 0, 32'h0, "R6 warm read");
        step(0, 1, 0, 32'h0, "R3 combinational read");
        // R7 / R10: cold write, bus and enable change while busy
        step(1, 0, 0, 32'd9, "R1 load address 9");
        step(0, 1, 1, 32'hAAAA_0001, "R7 cold write first cycle");
        step(1, 0, 1, 32'hBBBB_0002, "R10 enable dropped, address changed");
        for (int i = 0; i < LAT; i++) step(0, 0, 0, 32'hCCCC_0003, "R7 bus changes during busy");
        step(1, 0, 0, 32'd9, "R1 reload address 9");
        step(0, 1, 0, 32'h0, "R7 held data stored");
        // R4: warm write then read next cycle
        step(0, 1, 1, 32'h1234_5678, "R4 warm write");
        step(0, 1, 0, 32'h0, "R4 read back");
        // R2: enable low with write select does not store
        step(0, 0, 1, 32'hDEAD_BEEF, "R2 no action");
        step(0, 1, 0, 32'h0, "R2 word unchanged");
        // R1: access in the load cycle uses the old address
        step(1, 1, 0, 32'd5, "R1 old address used");
        step(0, 1, 0, 32'h0, "R1 new address read");
        // R5 / R6: sweep several cold writes then warm reads
        for (int w = 20; w < 28; w++) begin
            step(1, 0, 0, w, "R1 sweep address");
            step(0, 1, 1, 32'h5000_0000 + w, "R5 sweep cold write");
            for (int k = 0; k < LAT; k++) step(0, 1, 1, 32'h7000_0000 + w, "R5 sweep hold enable");
        end
        for (int w = 20; w < 28; w++) begin
            step(1, 0, 0, w, "R1 sweep reload");
            step(0, 1, 0, 32'h0, "R6 sweep warm read");
        end
        // R8: read select with busy from a cold word, then idle
        step(1, 0, 0, 32'd40, "R1 load address 40");
        step(0, 1, 0, 32'h0, "R8 no drive while busy");
        step(0, 1, 1, 32'h0, "R8 no drive on write select");
        for (int i = 0; i < LAT; i++) step(0, 0, 0, 32'h0, "R8 idle after access");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule